// File: doc/BRIEF.md
# Four-Channel Timer Edge Capture Unit

This block watches four asynchronous input pins. When a selected edge appears on a pin, it copies the current value of a free-running timer into that pin's own capture register. Each pin is first synchronized and then edge-detected. A single edge decision per pin does two things: it loads the capture register, and it sets a sticky event flag for that pin. A set flag raises an interrupt line when its enable bit is on. The same flag serves a pin used only as an external interrupt source, with no capture read-out. The timer value comes in as an input, and the interrupt lines go to an external controller.

Software uses a byte-wide register port with a write strobe and a combinational read. Through it, software picks the edges, enables interrupts, clears flags and reads each captured value as two bytes. Each channel has one bit for the rising edge and one for the falling edge. Setting both bits gives capture on either edge. Clearing both bits turns the channel off completely.

Top module: `tcap_unit`

## Requirements
- R1: After reset, every capture register, the edge-select register (address 0x0), the event flag register (address 0x1) and the interrupt enable register (address 0x2) read 0, and all interrupt lines are low.
- R2: When bit 2n of the edge-select register is 1, a rising edge on pin n loads capture register n with the timer value. The value taken is the one present at the third rising clock edge after the pin changes (two synchronizer flops, then the edge-detect cycle).
- R3: When bit 2n+1 of the edge-select register is 1, a falling edge on pin n loads capture register n the same way. A rising edge then has no effect when bit 2n is 0.
- R4: When both bits of channel n are 1, every transition of pin n, rising or falling, captures.
- R5: When both bits of channel n are 0, transitions of pin n change neither capture register n nor flag n.
- R6: A qualifying edge on pin n sets bit n of the event flag register (bits 3:0). The flag stays set until software clears it.
- R7: Writing the flag register clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1. When a clear and a hardware set land in the same cycle, the flag ends up set.
- R8: Interrupt line n is high exactly when flag n is 1 and bit n of the interrupt enable register is 1.
- R9: Capture register n reads its low byte at address 0x8+2n and its high byte at address 0x9+2n. Writes to those addresses change nothing.
- R10: Each pin transition is detected exactly once. Holding a pin level after an edge produces no further capture or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Free-running timer value to sample |
| cap_pin | input | 4 | Asynchronous capture / interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from address) |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
The timer input steps every clock, so the bench can pin down exactly which cycle a capture samples. A synchronizer or detector that is one flop too short or too long stores a value that is off by one.

Each edge polarity is tested with the opposite bit cleared. A design that swapped bit 2n and bit 2n+1, or that ignored the select bits, captures on the wrong transition. A channel with both bits cleared must stay silent.

A flag clear is timed to land on the very cycle of a hardware set, which exposes a design where the clear wins. Writes of ones to the flag register, and writes to the capture addresses, must leave state unchanged. Long idle stretches after an edge would expose a level-sensitive detector that fires again.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned ADDR_EDGE_SEL = 0;
  localparam int unsigned ADDR_FLAGS    = 1;
  localparam int unsigned ADDR_IRQ_EN   = 2;
  localparam int unsigned ADDR_CAP_BASE = 8;

  typedef logic [REG_W-1:0] reg_byte_t;

  // sel[0] arms the rising edge, sel[1] arms the falling edge
  function automatic logic edge_qualifies(input logic rise, input logic fall,
                                          input logic [1:0] sel);
    return (rise & sel[0]) | (fall & sel[1]);
  endfunction

  // hardware set has priority over a software clear (write of 0)
  function automatic logic flag_update(input logic cur, input logic hw_set,
                                       input logic wr_hit, input logic wbit);
    return hw_set | (cur & ~(wr_hit & ~wbit));
  endfunction

  function automatic int unsigned cap_byte_addr(input int unsigned ch,
                                                input int unsigned byte_idx,
                                                input int unsigned bytes_per_cap);
    return ADDR_CAP_BASE + ch * bytes_per_cap + byte_idx;
  endfunction
endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;
  logic                   level;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], pin_async};
      end
    end
  endgenerate

  assign level = chain[MSB];

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] timer_val,
  output logic [TW-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= timer_val;
  end
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned TW  = 16,
  parameter int unsigned AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  reg_byte_t         bus_wdata,
  output reg_byte_t         bus_rdata,
  input  logic [NCH-1:0]    hit,
  input  logic [NCH*TW-1:0] cap_flat,
  output logic [2*NCH-1:0]  edge_sel,
  output logic [NCH-1:0]    flags,
  output logic [NCH-1:0]    ien,
  output logic [NCH-1:0]    irq
);
  localparam int unsigned SEL_W = 2 * NCH;
  localparam int unsigned BPC   = TW / REG_W;

  logic wr_sel, wr_flags, wr_ien;

  assign wr_sel   = bus_wr && (int'(bus_addr) == ADDR_EDGE_SEL);
  assign wr_flags = bus_wr && (int'(bus_addr) == ADDR_FLAGS);
  assign wr_ien   = bus_wr && (int'(bus_addr) == ADDR_IRQ_EN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_sel <= '0;
      ien      <= '0;
    end else begin
      if (wr_sel) edge_sel <= bus_wdata[SEL_W-1:0];
      if (wr_ien) ien      <= bus_wdata[NCH-1:0];
    end
  end

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n) flags[n] <= 1'b0;
        else        flags[n] <= flag_update(flags[n], hit[n], wr_flags, bus_wdata[n]);
      end
    end
  endgenerate

  assign irq = flags & ien;

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == ADDR_EDGE_SEL) bus_rdata = REG_W'(edge_sel);
    if (int'(bus_addr) == ADDR_FLAGS)    bus_rdata = REG_W'(flags);
    if (int'(bus_addr) == ADDR_IRQ_EN)   bus_rdata = REG_W'(ien);
    for (int ch = 0; ch < NCH; ch++) begin
      for (int b = 0; b < BPC; b++) begin
        if (int'(bus_addr) == cap_byte_addr(ch, b, BPC))
          bus_rdata = cap_flat[ch*TW + b*REG_W +: REG_W];
      end
    end
  end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned TW          = 16,
  parameter int unsigned AW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  timer_val,
  input  logic [NCH-1:0] cap_pin,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0]    rise_det;
  logic [NCH-1:0]    fall_det;
  logic [NCH-1:0]    edge_hit;
  logic [NCH*TW-1:0] cap_flat;
  logic [2*NCH-1:0]  edge_sel;
  logic [NCH-1:0]    flags;
  logic [NCH-1:0]    ien;

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      tcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin[n]),
        .rise      (rise_det[n]),
        .fall      (fall_det[n])
      );

      assign edge_hit[n] = edge_qualifies(rise_det[n], fall_det[n], edge_sel[2*n +: 2]);

      tcap_capture #(.TW(TW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (edge_hit[n]),
        .timer_val (timer_val),
        .value     (cap_flat[n*TW +: TW])
      );
    end
  endgenerate

  tcap_regs #(.NCH(NCH), .TW(TW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hit       (edge_hit),
    .cap_flat  (cap_flat),
    .edge_sel  (edge_sel),
    .flags     (flags),
    .ien       (ien),
    .irq       (irq)
  );
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned TW  = 16,
  parameter int unsigned AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TW-1:0]     timer_val,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    rise_det,
  input logic [NCH-1:0]    fall_det,
  input logic [NCH-1:0]    edge_hit,
  input logic [NCH*TW-1:0] cap_flat,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    ien
);
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      p_cap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[g] |=> (cap_flat[g*TW +: TW] == $past(timer_val)));

      p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_hit[g] |=> $stable(cap_flat[g*TW +: TW]));

      p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[g] |=> flags[g]);

      p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[g]) |-> $past(bus_wr && (bus_addr == AW'(1)) && !bus_wdata[g]));

      p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq[g] |-> (flags[g] && ien[g]));

      p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_det[g] |=> !rise_det[g]);

      p_single_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_det[g] |=> !fall_det[g]);
    end
  endgenerate
endmodule

bind tcap_unit tcap_chk #(.NCH(NCH), .TW(TW), .AW(AW)) u_chk (.*);

// File: tb/sim_tcap_unit.sv
module sim_tcap_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_val;
  logic [3:0]  cap_pin = 4'h0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] tmr = 16'h1000;
  logic [15:0] m_cap [4];
  logic [3:0]  m_flag = 4'h0;
  logic [7:0]  m_sel = 8'h0;
  logic [3:0]  m_ien = 4'h0;

  assign timer_val = tmr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcap_unit u0 (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_pin(cap_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic bit qualifies(input logic [7:0] sel, input int ch, input logic new_lvl);
    return new_lvl ? sel[2*ch] : sel[2*ch+1];
  endfunction

  task automatic tick();
    @(negedge clk);
    tmr = tmr + 16'd1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
    if (a == 4'h0) m_sel = d;
    if (a == 4'h1) m_flag = m_flag & d[3:0];
    if (a == 4'h2) m_ien = d[3:0];
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic read_cap(input int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_read(4'(8 + 2*ch), lo);
    reg_read(4'(9 + 2*ch), hi);
    v = {hi, lo};
  endtask

  task automatic toggle(input int ch);
    logic lvl;
    logic [15:0] exp_t;
    lvl = ~cap_pin[ch];
    cap_pin[ch] = lvl;
    exp_t = tmr + 16'd2;
    tick(); tick(); tick();
    if (qualifies(m_sel, ch, lvl)) begin
      m_cap[ch] = exp_t;
      m_flag[ch] = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    logic [7:0] d;
    for (int ch = 0; ch < 4; ch++) begin
      read_cap(ch, v);
      chk(req, v, m_cap[ch]);
    end
    reg_read(4'h1, d);
    chk(req, d, {4'h0, m_flag});
    #1;
    chk(req, irq, m_flag & m_ien);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v, exp_t;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) m_cap[i] = 16'h0;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      reg_read(4'(a), d);
      chk("R1 reg", d, 0);
    end
    for (int ch = 0; ch < 4; ch++) begin
      read_cap(ch, v);
      chk("R1 cap", v, 0);
    end
    chk("R1 irq", irq, 0);

    // R2 rising edge only on ch0
    reg_write(4'h0, 8'b0000_0001);
    toggle(0);
    check_all("R2 rise capture");
    toggle(0);
    check_all("R2 fall ignored");

    // R3 falling edge only on ch1
    reg_write(4'h0, 8'b0000_1000);
    toggle(1);
    check_all("R3 rise ignored");
    toggle(1);
    check_all("R3 fall capture");

    // R4 both edges on ch2
    reg_write(4'h0, 8'b0011_0000);
    toggle(2);
    check_all("R4 rise");
    toggle(2);
    check_all("R4 fall");

    // R5 ch3 disabled
    reg_write(4'h0, 8'b0000_0000);
    toggle(3);
    toggle(3);
    check_all("R5 disabled channel");

    // R6 flags sticky
    repeat (20) tick();
    check_all("R6 sticky flags");

    // R8 interrupt gating
    reg_write(4'h2, 8'h05);
    check_all("R8 irq enable");

    // R7 clear by 0, keep by 1
    reg_write(4'h1, 8'hFE);
    check_all("R7 clear ch0");
    reg_write(4'h1, 8'hFF);
    check_all("R7 ones keep");

    // R7 set wins over clear in the same cycle
    reg_write(4'h0, 8'b0000_0001);
    reg_write(4'h1, 8'h00);
    cap_pin[0] = 1'b1;
    exp_t = tmr + 16'd2;
    tick(); tick();
    bus_wr = 1'b1; bus_addr = 4'h1; bus_wdata = 8'h00;
    tick();
    bus_wr = 1'b0;
    m_cap[0] = exp_t;
    m_flag = 4'b0001;
    check_all("R7 set beats clear");

    // R9 writes to capture addresses ignored
    for (int a = 8; a < 16; a++) reg_write(4'(a), 8'hA5);
    check_all("R9 cap write ignored");

    // R10 no re-detect while level held
    reg_write(4'h0, 8'hFF);
    reg_write(4'h1, 8'h00);
    repeat (30) tick();
    check_all("R10 held level");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int ch;
      if (($urandom % 4) == 0) reg_write(4'h0, 8'($urandom));
      if (($urandom % 5) == 0) reg_write(4'h2, 8'($urandom));
      if (($urandom % 3) == 0) reg_write(4'h1, 8'($urandom));
      repeat ($urandom % 4) tick();
      ch = int'($urandom % 4);
      toggle(ch);
      check_all("R2 R3 R4 R5 R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule